// File: doc/BRIEF.md
# Shared-PLL Power and Readiness Sequencer

This block decides when each lane of an eight-lane serializer may drive its line. All lanes share one clock-multiplying PLL. A master power control starts and stops that PLL. Each lane also has its own power control and a common output-enable line. The analog events are modelled as counts of word-clock cycles: PLL lock is a fixed number of cycles after master release, and lane start-up is a fixed number of cycles after the lane is released.

The block produces three outputs. `pll_run` is the run request for the shared PLL. `lane_ready` is one readiness flag per lane. `lane_drive` is one drive enable per lane, and it gates the serializer instances. A lane drives only when three things hold: the master is up and its count is complete, the lane's own count is complete, and the common enable is high. The common enable acts on the drive outputs only. It leaves every counter alone, so a lane returns to its earlier state when the enable comes back.

Top module: `lane_power_seq`

## Requirements
- R1: While `rst_n` is low, and after reset with both power controls low, `pll_run`, every `lane_ready` bit and every `lane_drive` bit are 0.
- R2: When `master_pd_n` is sampled low at a rising edge, `pll_run` and every `lane_ready` bit are 0 after that edge. `lane_ready` bits are never 1 while `pll_run` is 0.
- R3: The master initialization completes at the MASTER_WAIT-th (default 513) consecutive rising edge that samples `master_pd_n` high. No lane may start counting before that.
- R4: A lane whose `lane_pd_n` bit is already high when the master is released raises `lane_ready` exactly MASTER_WAIT+LANE_WAIT (default 576) rising edges after the release, and not one edge earlier.
- R5: When a lane's `lane_pd_n` bit is sampled low, that lane's `lane_ready` is 0 after that edge. The other lanes' flags are unchanged.
- R6: When a lane is released while the master is complete, its `lane_ready` rises after exactly LANE_WAIT (default 63) rising edges with the bit high.
- R7: `lane_drive[i]` equals `lane_ready[i]` AND `drive_en_all`, combinationally. With `drive_en_all` low, all eight drive bits are 0 in the same cycle.
- R8: `drive_en_all` resets no counter. A lane that counts while the enable is low becomes ready on schedule, and all drives return as soon as the enable goes high again.
- R9: A low pulse on `master_pd_n` during master initialization restarts the full MASTER_WAIT count.
- R10: A low pulse on a lane's `lane_pd_n` during its start-up count restarts the full LANE_WAIT count for that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_pd_n | input | 1 | Master power control, low = whole block down |
| lane_pd_n | input | 8 | Per-lane power control, low = lane down |
| drive_en_all | input | 1 | Common output enable, low = all lanes undriven |
| pll_run | output | 1 | Run request for the shared PLL |
| lane_ready | output | 8 | Lane start-up complete |
| lane_drive | output | 8 | Lane may drive its serial line |

## Verification
The bench samples readiness one edge before and exactly at the expected completion of each count. A count that is off by one, either way, therefore fails at one of the two samples. It pulses a power control low in the middle of a count. A design that paused the count instead of restarting it would raise the flag far too early. It restarts a lane while the common enable is low. A design that let the enable clear counters would then show no drive when the enable returns. It also drops the master while lanes are ready. A lane counter that watched only the registered master-done flag would hold its flag one cycle too long.

// File: rtl/lps_pkg.sv
package lps_pkg;
  // True when the count stepping from cnt lands exactly on lim.
  function automatic logic last_step(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

  // Width needed to hold the values 0..lim.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/lps_master_seq.sv
module lps_master_seq #(
  parameter int unsigned MASTER_WAIT = 513
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic pll_run,
  output logic done
);
  localparam int unsigned W = lps_pkg::cnt_width(MASTER_WAIT);

  logic [W-1:0] cnt;
  logic         step_hit;

  assign step_hit = lps_pkg::last_step(32'(cnt), MASTER_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      done    <= 1'b0;
      pll_run <= 1'b0;
    end else if (!pd_n) begin
      cnt     <= '0;
      done    <= 1'b0;
      pll_run <= 1'b0;
    end else begin
      pll_run <= 1'b1;
      if (!done) begin
        cnt  <= cnt + W'(1);
        done <= step_hit;
      end
    end
  end

  AST_MASTER_PD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!pll_run && !done)); // R2
  AST_MASTER_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == W'(MASTER_WAIT))); // R3
  AST_MASTER_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pd_n)); // R9
endmodule

// File: rtl/lps_lane_seq.sv
module lps_lane_seq #(
  parameter int unsigned LANE_WAIT = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_pd_n,
  input  logic master_done,
  input  logic pd_n,
  output logic ready
);
  localparam int unsigned W = lps_pkg::cnt_width(LANE_WAIT);

  logic [W-1:0] cnt;
  logic         hold_clear;
  logic         step_hit;

  // Either power control, or an unfinished master, holds the lane cleared.
  assign hold_clear = !master_pd_n || !master_done || !pd_n;
  assign step_hit   = lps_pkg::last_step(32'(cnt), LANE_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (hold_clear) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt   <= cnt + W'(1);
      ready <= step_hit;
    end
  end

  AST_LANE_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> master_done); // R4
  AST_LANE_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !ready); // R5
  AST_LANE_COUNT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cnt == W'(LANE_WAIT))); // R6
  AST_LANE_RISE_NEEDS_PD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(pd_n)); // R10
endmodule

// File: rtl/lane_power_seq.sv
module lane_power_seq #(
  parameter int unsigned NUM_LANES   = 8,
  parameter int unsigned MASTER_WAIT = 513,
  parameter int unsigned LANE_WAIT   = 63
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 master_pd_n,
  input  logic [NUM_LANES-1:0] lane_pd_n,
  input  logic                 drive_en_all,
  output logic                 pll_run,
  output logic [NUM_LANES-1:0] lane_ready,
  output logic [NUM_LANES-1:0] lane_drive
);
  logic master_done;

  lps_master_seq #(.MASTER_WAIT(MASTER_WAIT)) master_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pd_n   (master_pd_n),
    .pll_run(pll_run),
    .done   (master_done)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lps_lane_seq #(.LANE_WAIT(LANE_WAIT)) lane_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .master_pd_n(master_pd_n),
      .master_done(master_done),
      .pd_n       (lane_pd_n[g]),
      .ready      (lane_ready[g])
    );
  end

  // Common enable gates drive only; counters never see it.
  assign lane_drive = lane_ready & {NUM_LANES{drive_en_all}};

  AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_drive) |-> drive_en_all); // R7
  AST_READY_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_ready) |-> pll_run); // R2
  AST_DRIVE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_drive & ~lane_ready) == '0); // R7
endmodule

// File: tb/lane_power_seq_tb_top.sv
module lane_power_seq_tb_top;
  localparam int unsigned MW = 513;
  localparam int unsigned LW = 63;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_pd_n = 1'b0;
  logic [7:0] lane_pd_n = 8'h00;
  logic       drive_en_all = 1'b0;
  logic       pll_run;
  logic [7:0] lane_ready, lane_drive;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lane_power_seq dut_i (
    .clk(clk), .rst_n(rst_n), .master_pd_n(master_pd_n), .lane_pd_n(lane_pd_n),
    .drive_en_all(drive_en_all), .pll_run(pll_run), .lane_ready(lane_ready),
    .lane_drive(lane_drive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pll in reset", 32'(pll_run), 32'h0);
    chk("R1 ready in reset", 32'(lane_ready), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    edges(5);
    chk("R1 pll after reset", 32'(pll_run), 32'h0);
    chk("R1 drive after reset", 32'(lane_drive), 32'h0);
  endtask

  task automatic t_boot;
    lane_pd_n = 8'hFF; drive_en_all = 1'b1; master_pd_n = 1'b1;
    edges(1);
    chk("R2 pll runs", 32'(pll_run), 32'h1);
    edges(MW);
    chk("R3 no lane before master+lane", 32'(lane_ready), 32'h0);
    edges(LW - 2);
    chk("R4 one edge early", 32'(lane_ready), 32'h0);
    edges(1);
    chk("R4 ready on time", 32'(lane_ready), 32'hFF);
    chk("R7 drive on", 32'(lane_drive), 32'hFF);
  endtask

  task automatic t_lane_cycle;
    lane_pd_n[3] = 1'b0;
    edges(1);
    chk("R5 lane3 cleared, others kept", 32'(lane_ready), 32'hF7);
    lane_pd_n[3] = 1'b1;
    edges(LW - 1);
    chk("R6 lane3 early", 32'(lane_ready), 32'hF7);
    edges(1);
    chk("R6 lane3 ready", 32'(lane_ready), 32'hFF);
  endtask

  task automatic t_lane_restart;
    lane_pd_n[5] = 1'b0; edges(1); lane_pd_n[5] = 1'b1;
    edges(30);
    lane_pd_n[5] = 1'b0; edges(1); lane_pd_n[5] = 1'b1;
    edges(LW - 1);
    chk("R10 lane5 restarted, not yet", 32'(lane_ready), 32'hDF);
    edges(1);
    chk("R10 lane5 ready after full count", 32'(lane_ready), 32'hFF);
  endtask

  task automatic t_enable;
    drive_en_all = 1'b0; #1;
    chk("R7 drives off same cycle", 32'(lane_drive), 32'h00);
    chk("R8 ready kept while disabled", 32'(lane_ready), 32'hFF);
    @(negedge clk);
    lane_pd_n[2] = 1'b0; edges(1); lane_pd_n[2] = 1'b1;
    edges(LW);
    chk("R8 lane2 counted while disabled", 32'(lane_ready), 32'hFF);
    chk("R7 still no drive", 32'(lane_drive), 32'h00);
    drive_en_all = 1'b1; #1;
    chk("R8 drives resume", 32'(lane_drive), 32'hFF);
    @(negedge clk);
  endtask

  task automatic t_master_down;
    master_pd_n = 1'b0;
    edges(1);
    chk("R2 pll stops", 32'(pll_run), 32'h0);
    chk("R2 all ready cleared", 32'(lane_ready), 32'h00);
    chk("R2 all drive off", 32'(lane_drive), 32'h00);
    master_pd_n = 1'b1;
    edges(200);
    master_pd_n = 1'b0; edges(1); master_pd_n = 1'b1;
    edges(MW + LW - 1);
    chk("R9 restart not done early", 32'(lane_ready), 32'h00);
    edges(1);
    chk("R9 ready after full restart", 32'(lane_ready), 32'hFF);
  endtask

  initial begin
    fork
      begin
        edges(3);
        t_reset();
        t_boot();
        t_lane_cycle();
        t_lane_restart();
        t_enable();
        t_master_down();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule